// File: doc/BRIEF.md
# EDO DRAM Device-Side Emulator

This block behaves like the device end of an extended-data-out DRAM so that a memory controller can be checked against it in simulation or on a prototype. It samples the active-low strobes once per clock: a row strobe, an upper-lane and a lower-lane column strobe, a write enable and an output enable. A nine-bit multiplexed address and sixteen bits of write data go with them. The block stores data in a small parameterised array. The row is taken from the low address bits at the row strobe fall, and the column from the low address bits at the fall of the internal column strobe.

The block sorts each cycle into one of several kinds: read, write, byte read and byte write, page-mode access, row-only refresh, refresh with the column strobe first (driven by an internal nine-bit row counter), and hidden refresh. Read data stays driven after the column strobes rise, in the extended-data-out manner. It also keeps a refresh age for every row. If a row goes a full refresh period without being refreshed, a sticky error flag is raised and the row's index is reported.

Top module: `edo_dram_emu`

## Requirements
- R1: While reset is held and directly after it, `rdata` and `drive_en` are zero, `refresh_err` is low and `refresh_err_row` is zero. The array holds all zeros.
- R2: The internal column strobe goes low in the first cycle in which either lane strobe is low. It goes high only once both lane strobes are high. The column is captured only in the cycle of that internal fall. A lane strobe that falls while the other lane is already low reuses the captured column.
- R3: Row and column indices are the low ROW_BITS and COL_BITS bits of `addr` (address modulo array size). The row is captured in the cycle where `ras_n` is first sampled low.
- R4: In an access cycle with `we_n` high and `oe_n` low, a lane whose strobe is sampled low loads its byte into `rdata` on that clock edge and sets its `drive_en` bit (bit 0 = `rdata[7:0]` with `lcas_n`, bit 1 = `rdata[15:8]` with `ucas_n`). A lane whose strobe is high leaves its bit at 0.
- R5: A lane's byte of `wdata` is written in the first cycle where its strobe and `we_n` are both sampled low, that is, at the later of the two falls. Changes to `wdata` while both stay low are not written. A `we_n` fall with both strobes high writes nothing.
- R6: Once driven, a lane stays driven with unchanged data after its strobe rises. It is cleared one cycle after `oe_n` is sampled high, after `we_n` is sampled low, or after `ras_n` and both lane strobes are all sampled high.
- R7: With `ras_n` held low, each new fall of the internal column strobe selects a new column in the same row for reads or writes.
- R8: If a lane strobe is low when `ras_n` is first sampled low, the cycle is a counter refresh. It touches no data, turns no lane on, refreshes the row given by the nine-bit counter's low bits, and the counter then advances by one.
- R9: Any other `ras_n` fall (row-only refresh, read, write) refreshes the addressed row.
- R10: If `ras_n` rises and falls again while a lane strobe stays low after a read, the driven lanes and their data are held throughout (hidden refresh). That `ras_n` fall is a counter refresh.
- R11: A row not refreshed for REFRESH_CYCLES clocks sets `refresh_err`. The flag stays set until reset, and `refresh_err_row` then holds the index of the first row to expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| drive_en | output | 2 | Per-lane output drive (1 = driven, 0 = high impedance) |
| refresh_err | output | 1 | Sticky refresh deadline violation |
| refresh_err_row | output | 9 | Index of the first row that expired |

## Verification
The assertions assume that every strobe level is held for at least one sampling clock. They also assume that the address is valid in the cycle a strobe is first sampled low, and that inputs never change near the sampling edge. The bench therefore drives every input on the falling clock edge and holds each level for whole cycles. It returns `ras_n` high before a new access and presents the column in the same cycle as the first lane strobe fall. Random operations are mixed with bursts of sixteen counter refreshes so that no row expires, except in the final test, which lets exactly one row expire on purpose.

// File: rtl/edo_pkg.sv
// Package: shared types for the EDO DRAM emulator.
// Assumes nothing beyond IEEE 1800-2017.
package edo_pkg;

    // Kind of row cycle currently open
    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ACCESS  = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_kind_e;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;

endpackage

// File: rtl/edo_cycle_decode.sv
// Module: edo_cycle_decode
// Detects strobe edges from one-cycle-old samples, derives the internal
// column strobe (first lane low, last lane high), classifies each row
// cycle and captures row and column indices. It also owns the refresh
// counter used for column-first refresh.
// Assumes each strobe level lasts at least one clock and the address is
// valid in the cycle a strobe is first sampled low.
module edo_cycle_decode
    import edo_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic [LANES-1:0]    cas_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic                access_active,
    output logic                icas_n,
    output logic                icas_fall,
    output logic [LANES-1:0]    lane_fall,
    output logic                we_fall,
    output logic [ROW_BITS-1:0] row_idx,
    output logic [COL_BITS-1:0] col_idx,
    output logic                refresh_pulse,
    output logic [ROW_BITS-1:0] refresh_row
);

    logic                ras_q;
    logic [LANES-1:0]    cas_q;
    logic                we_q;
    logic                icas_q;
    logic                ras_fall;
    logic                ras_rise;
    cyc_kind_e           kind_q;
    cyc_kind_e           kind_now;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic [ADDR_W-1:0]   cbr_cnt;
    logic                unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:ROW_BITS];

    // Internal column strobe: low while any lane strobe is low
    assign icas_n    = &cas_n;
    assign icas_fall = icas_q & ~icas_n;
    assign lane_fall = cas_q & ~cas_n;
    assign we_fall   = we_q & ~we_n;
    assign ras_fall  = ras_q & ~ras_n;
    assign ras_rise  = ~ras_q & ras_n;

    // Cycle kind as seen in this cycle, including a fall happening now
    always_comb begin
        if (ras_fall) begin
            kind_now = icas_n ? CYC_ACCESS : CYC_REFRESH;
        end else begin
            kind_now = kind_q;
        end
    end

    assign access_active = (kind_now == CYC_ACCESS) && !ras_n;
    assign row_idx       = row_q;
    assign col_idx       = icas_fall ? addr[COL_BITS-1:0] : col_q;
    assign refresh_pulse = ras_fall;
    assign refresh_row   = icas_n ? addr[ROW_BITS-1:0] : cbr_cnt[ROW_BITS-1:0];

    // Previous-cycle strobe samples for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q  <= 1'b1;
            cas_q  <= '1;
            we_q   <= 1'b1;
            icas_q <= 1'b1;
        end else begin
            ras_q  <= ras_n;
            cas_q  <= cas_n;
            we_q   <= we_n;
            icas_q <= icas_n;
        end
    end

    // Cycle kind register, opened at row strobe fall, closed at its rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= CYC_IDLE;
        end else if (ras_fall) begin
            kind_q <= kind_now;
        end else if (ras_rise) begin
            kind_q <= CYC_IDLE;
        end
    end

    // Row capture on a row strobe fall of an access cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (ras_fall && icas_n) begin
            row_q <= addr[ROW_BITS-1:0];
        end
    end

    // Column capture on the internal column strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (icas_fall) begin
            col_q <= addr[COL_BITS-1:0];
        end
    end

    // Refresh counter advances after each column-first refresh
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbr_cnt <= '0;
        end else if (ras_fall && !icas_n) begin
            cbr_cnt <= cbr_cnt + 1'b1;
        end
    end

    // R8: counter advances by exactly one on a column-first refresh
    p_cbr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && !icas_n) |=> (cbr_cnt == $past(cbr_cnt) + 1'b1));

    // R2: column stays put while the internal strobe remains low
    p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!icas_n && !icas_fall) |-> (col_idx == $past(col_idx)));

    // R8: no access can open while a lane strobe was low at the row fall
    p_refresh_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && !icas_n) |-> !access_active);

endmodule

// File: rtl/edo_lane_store.sv
// Module: edo_lane_store
// Storage array with per-lane write strobes and per-lane registered read
// data with extended-data-out hold. Writes take a lane's byte at the later
// of its strobe fall and the write-enable fall.
// Assumes access_active and the indices come from edo_cycle_decode.
module edo_lane_store
    import edo_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     access_active,
    input  logic                     icas_n,
    input  logic                     icas_fall,
    input  logic [LANES-1:0]         lane_fall,
    input  logic                     we_fall,
    input  logic                     ras_n,
    input  logic [LANES-1:0]         cas_n,
    input  logic                     we_n,
    input  logic                     oe_n,
    input  logic [ROW_BITS-1:0]      row_idx,
    input  logic [COL_BITS-1:0]      col_idx,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic [LANES-1:0]         drive_en
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int IDX_W  = ROW_BITS + COL_BITS;
    localparam int DEPTH  = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] rd_word;
    logic [LANES-1:0]  wr_en;
    logic              drive_kill;

    assign word_idx   = {row_idx, col_idx};
    assign rd_word    = mem[word_idx];
    assign drive_kill = oe_n || !we_n || (ras_n && icas_n);

    // Array update: reset clears, then each enabled lane writes its byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_en[l]) begin
                    mem[word_idx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Write at the later of this lane's strobe fall and the WE fall
        assign wr_en[g] = access_active && !cas_n[g] && !we_n
                          && (lane_fall[g] || we_fall);

        // Read data and drive state for this lane, with EDO hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                drive_en[g]                 <= 1'b0;
                rdata[g*LANE_W +: LANE_W]   <= '0;
            end else if (drive_kill) begin
                drive_en[g]                 <= 1'b0;
            end else if (access_active && !cas_n[g]) begin
                drive_en[g]                 <= 1'b1;
                rdata[g*LANE_W +: LANE_W]   <= rd_word[g*LANE_W +: LANE_W];
            end else if (access_active && icas_fall) begin
                drive_en[g]                 <= 1'b0;
            end
        end

        // R4: a lane only starts driving after its own strobe was low
        p_drive_needs_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drive_en[g]) |-> $past(!cas_n[g]));

        // R8: a lane never starts driving out of a refresh or idle cycle
        p_no_drive_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drive_en[g]) |-> $past(access_active));

        // R6: held output data does not change while the strobe is high
        p_edo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(cas_n[g]) && drive_en[g] && $past(drive_en[g]))
            |-> $stable(rdata[g*LANE_W +: LANE_W]));
    end

    // R6: output enable high turns every lane off on the next edge
    p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (drive_en == '0));

endmodule

// File: rtl/edo_refresh_watch.sv
// Module: edo_refresh_watch
// Keeps a saturating age per row, cleared by each refresh of that row.
// The first row to reach the limit raises a sticky error and its index
// is reported.
// Assumes at most one refresh per cycle.
module edo_refresh_watch #(
    parameter int ROW_BITS       = 4,
    parameter int ADDR_W         = 9,
    parameter int REFRESH_CYCLES = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refresh_pulse,
    input  logic [ROW_BITS-1:0] refresh_row,
    output logic                refresh_err,
    output logic [ADDR_W-1:0]   refresh_err_row
);

    localparam int ROWS  = 1 << ROW_BITS;
    localparam int AGE_W = $clog2(REFRESH_CYCLES + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(REFRESH_CYCLES);

    logic [AGE_W-1:0]    age [ROWS];
    logic [ROWS-1:0]     expired;
    logic                any_expired;
    logic [ROW_BITS-1:0] first_row;

    // Per-row age: zero on refresh, otherwise count up to the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                age[r] <= '0;
            end
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (refresh_pulse && (refresh_row == ROW_BITS'(r))) begin
                    age[r] <= '0;
                end else if (age[r] != AGE_MAX) begin
                    age[r] <= age[r] + 1'b1;
                end
            end
        end
    end

    // Lowest-index expired row
    always_comb begin
        first_row = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            expired[r] = (age[r] == AGE_MAX);
            if (expired[r]) begin
                first_row = ROW_BITS'(r);
            end
        end
    end

    assign any_expired = |expired;

    // Sticky error flag with the first failing row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_err     <= 1'b0;
            refresh_err_row <= '0;
        end else if (!refresh_err && any_expired) begin
            refresh_err     <= 1'b1;
            refresh_err_row <= ADDR_W'(first_row);
        end
    end

    // R11: the error flag and its row never change once raised
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_err |=> (refresh_err && $stable(refresh_err_row)));

    // R11: a flag only appears when some row had reached its limit
    p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_err) |-> $past(any_expired));

endmodule

// File: rtl/edo_dram_emu.sv
// Module: edo_dram_emu (top)
// Device-side EDO DRAM emulator: strobe decoding, byte-lane storage with
// EDO read hold, and per-row refresh deadline monitoring.
// Assumes inputs are synchronous to clk and each level lasts a full clock.
module edo_dram_emu
    import edo_pkg::*;
#(
    parameter int ADDR_W         = 9,
    parameter int ROW_BITS       = 4,
    parameter int COL_BITS       = 4,
    parameter int REFRESH_CYCLES = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ras_n,
    input  logic                     ucas_n,
    input  logic                     lcas_n,
    input  logic                     we_n,
    input  logic                     oe_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic [LANES-1:0]         drive_en,
    output logic                     refresh_err,
    output logic [ADDR_W-1:0]        refresh_err_row
);

    logic [LANES-1:0]    cas_n;
    logic                access_active;
    logic                icas_n;
    logic                icas_fall;
    logic [LANES-1:0]    lane_fall;
    logic                we_fall;
    logic [ROW_BITS-1:0] row_idx;
    logic [COL_BITS-1:0] col_idx;
    logic                refresh_pulse;
    logic [ROW_BITS-1:0] refresh_row;

    assign cas_n = {ucas_n, lcas_n};

    edo_cycle_decode #(
        .ADDR_W   (ADDR_W),
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS)
    ) u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .addr          (addr),
        .access_active (access_active),
        .icas_n        (icas_n),
        .icas_fall     (icas_fall),
        .lane_fall     (lane_fall),
        .we_fall       (we_fall),
        .row_idx       (row_idx),
        .col_idx       (col_idx),
        .refresh_pulse (refresh_pulse),
        .refresh_row   (refresh_row)
    );

    edo_lane_store #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .access_active (access_active),
        .icas_n        (icas_n),
        .icas_fall     (icas_fall),
        .lane_fall     (lane_fall),
        .we_fall       (we_fall),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .oe_n          (oe_n),
        .row_idx       (row_idx),
        .col_idx       (col_idx),
        .wdata         (wdata),
        .rdata         (rdata),
        .drive_en      (drive_en)
    );

    edo_refresh_watch #(
        .ROW_BITS       (ROW_BITS),
        .ADDR_W         (ADDR_W),
        .REFRESH_CYCLES (REFRESH_CYCLES)
    ) u_watch (
        .clk             (clk),
        .rst_n           (rst_n),
        .refresh_pulse   (refresh_pulse),
        .refresh_row     (refresh_row),
        .refresh_err     (refresh_err),
        .refresh_err_row (refresh_err_row)
    );

    // R10: during a hidden refresh (row strobe high, column low) lanes hold
    p_hidden_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!icas_n && !oe_n && we_n && ras_n) |=> $stable(drive_en));

endmodule

// File: tb/tb_edo_dram_emu.sv
// Bench for edo_dram_emu: directed corner cases plus seeded random traffic
// checked against a reference array kept in the bench.
module tb_edo_dram_emu;

    localparam int LIMIT = 800;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ras_n, ucas_n, lcas_n, we_n, oe_n;
    logic [8:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  drive_en;
    logic        refresh_err;
    logic [8:0]  refresh_err_row;

    int          n_chk  = 0;
    int          n_fail = 0;
    int          cyc    = 0;
    int          cbr_model = 0;
    int          last_burst = 0;
    bit          done = 0;
    logic [15:0] ref_mem [16][16];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edo_dram_emu #(
        .ADDR_W (9), .ROW_BITS (4), .COL_BITS (4), .REFRESH_CYCLES (LIMIT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .ucas_n (ucas_n),
        .lcas_n (lcas_n), .we_n (we_n), .oe_n (oe_n), .addr (addr),
        .wdata (wdata), .rdata (rdata), .drive_en (drive_en),
        .refresh_err (refresh_err), .refresh_err_row (refresh_err_row)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] lanes);
        return {{8{lanes[1]}}, {8{lanes[0]}}};
    endfunction

    task automatic idle_all();
        ras_n = 1; ucas_n = 1; lcas_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic set_cas(input logic [1:0] lanes);
        lcas_n = ~lanes[0];
        ucas_n = ~lanes[1];
    endtask

    // Plain read with EDO hold and end-of-cycle checks (R3, R4, R6)
    task automatic do_read(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes);
        logic [15:0] m;
        m = lane_mask(lanes);
        ras_n = 0; addr = r; step();
        addr = c; we_n = 1; oe_n = 0; set_cas(lanes); step();
        check("R4 read data", rdata & m, ref_mem[r[3:0]][c[3:0]] & m);
        check("R4 lane drive", drive_en, lanes);
        set_cas(2'b00); step();
        check("R6 edo hold data", rdata & m, ref_mem[r[3:0]][c[3:0]] & m);
        check("R6 edo hold drive", drive_en, lanes);
        ras_n = 1; step();
        check("R6 off after ras and cas high", drive_en, 2'b00);
        oe_n = 1;
    endtask

    // Plain write, both falls in the same cycle (R5)
    task automatic do_write(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes,
                            input logic [15:0] d);
        logic [15:0] m;
        m = lane_mask(lanes);
        ras_n = 0; addr = r; step();
        addr = c; we_n = 0; oe_n = 1; wdata = d; set_cas(lanes); step();
        set_cas(2'b00); we_n = 1; wdata = $urandom; step();
        ras_n = 1; step();
        ref_mem[r[3:0]][c[3:0]] = (ref_mem[r[3:0]][c[3:0]] & ~m) | (d & m);
    endtask

    // Page-mode read across several columns in one row (R7)
    task automatic do_page_read(input logic [8:0] r, input logic [1:0] lanes);
        logic [15:0] m;
        m = lane_mask(lanes);
        ras_n = 0; addr = r; we_n = 1; oe_n = 0; step();
        for (int k = 0; k < 3; k++) begin
            logic [8:0] c;
            c = 9'($urandom);
            addr = c; set_cas(lanes); step();
            check("R7 page read data", rdata & m, ref_mem[r[3:0]][c[3:0]] & m);
            set_cas(2'b00); step();
            check("R7 page edo hold", drive_en, lanes);
        end
        ras_n = 1; step();
        oe_n = 1;
    endtask

    // Page-mode write across several columns (R7)
    task automatic do_page_write(input logic [8:0] r, input logic [1:0] lanes);
        logic [15:0] m;
        m = lane_mask(lanes);
        ras_n = 0; addr = r; oe_n = 1; step();
        for (int k = 0; k < 3; k++) begin
            logic [8:0]  c;
            logic [15:0] d;
            c = 9'($urandom); d = 16'($urandom);
            addr = c; wdata = d; we_n = 0; set_cas(lanes); step();
            set_cas(2'b00); we_n = 1; wdata = $urandom; step();
            ref_mem[r[3:0]][c[3:0]] = (ref_mem[r[3:0]][c[3:0]] & ~m) | (d & m);
        end
        ras_n = 1; step();
    endtask

    // Late write enable: data taken at WE fall, later changes ignored (R5)
    task automatic do_late_write(input logic [8:0] r, input logic [8:0] c, input logic [15:0] d);
        ras_n = 0; addr = r; step();
        addr = c; we_n = 1; oe_n = 1; wdata = ~d; set_cas(2'b11); step();
        we_n = 0; wdata = d; step();
        wdata = d ^ 16'h5a5a; step();
        set_cas(2'b00); we_n = 1; step();
        ras_n = 1; step();
        ref_mem[r[3:0]][c[3:0]] = d;
    endtask

    // Row-only refresh (R9)
    task automatic do_ras_only(input logic [8:0] r);
        ras_n = 0; addr = r; step();
        ras_n = 1; step();
    endtask

    // Column-first counter refresh, output enable low to tempt a drive (R8)
    task automatic do_cbr();
        oe_n = 0; we_n = 1; set_cas(2'b11); step();
        ras_n = 0; step();
        check("R8 no drive in refresh", drive_en, 2'b00);
        ras_n = 1; step();
        set_cas(2'b00); oe_n = 1; step();
        cbr_model++;
    endtask

    task automatic refresh_burst();
        for (int k = 0; k < 16; k++) begin
            ras_n = 1; set_cas(2'b11); step();
            ras_n = 0; step();
            ras_n = 1; step();
            set_cas(2'b00); step();
            cbr_model++;
        end
        last_burst = cyc;
    endtask

    // Read followed by a hidden refresh that keeps the data (R10)
    task automatic do_hidden(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes);
        logic [15:0] m;
        m = lane_mask(lanes);
        ras_n = 0; addr = r; step();
        addr = c; we_n = 1; oe_n = 0; set_cas(lanes); step();
        check("R10 first read", rdata & m, ref_mem[r[3:0]][c[3:0]] & m);
        ras_n = 1; step();
        check("R10 held after ras rise", drive_en, lanes);
        ras_n = 0; step();
        check("R10 held in refresh data", rdata & m, ref_mem[r[3:0]][c[3:0]] & m);
        check("R10 held in refresh drive", drive_en, lanes);
        ras_n = 1; step();
        set_cas(2'b00); step();
        check("R10 off after cas high", drive_en, 2'b00);
        oe_n = 1;
        cbr_model++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++)
                ref_mem[r][c] = '0;
        rst_n = 0; idle_all(); addr = '0; wdata = '0;
        repeat (3) step();
        check("R1 reset rdata", rdata, 16'h0);
        check("R1 reset drive", drive_en, 2'b00);
        check("R1 reset err", refresh_err, 1'b0);
        check("R1 reset err row", refresh_err_row, 9'h0);
        rst_n = 1; step();
        check("R1 after reset drive", drive_en, 2'b00);
        do_read(9'd7, 9'd9, 2'b11);

        // R5/R4 basic word write and byte-lane reads
        do_write(9'd3, 9'd5, 2'b11, 16'hbeef);
        do_read(9'd3, 9'd5, 2'b01);
        do_read(9'd3, 9'd5, 2'b10);
        do_read(9'd3, 9'd5, 2'b11);

        // R3 modulo addressing: high address bits ignored
        do_write(9'h1f3, 9'h0a5, 2'b11, 16'h1234);
        check("R3 modulo alias", ref_mem[3][5], 16'h1234);
        do_read(9'd3, 9'd5, 2'b11);

        // R2 staggered lane strobes keep the first captured column
        do_write(9'd4, 9'd1, 2'b11, 16'haa11);
        do_write(9'd4, 9'd2, 2'b11, 16'h55cc);
        ras_n = 0; addr = 9'd4; step();
        addr = 9'd1; we_n = 1; oe_n = 0; lcas_n = 0; step();
        addr = 9'd2; ucas_n = 0; step();
        check("R2 staggered both lanes col A", rdata, 16'haa11);
        lcas_n = 1; step();
        lcas_n = 0; step();
        check("R2 relowered lane keeps col A", rdata, 16'haa11);
        check("R2 both lanes driven", drive_en, 2'b11);
        set_cas(2'b00); ras_n = 1; step();
        oe_n = 1;

        // R5 staggered lane write: each lane takes data at its own fall
        ras_n = 0; addr = 9'd6; step();
        addr = 9'd6; we_n = 0; wdata = 16'h1122; lcas_n = 0; step();
        wdata = 16'h3344; ucas_n = 0; step();
        wdata = 16'h7788; step();
        set_cas(2'b00); we_n = 1; ras_n = 1; step();
        ref_mem[6][6] = 16'h3322;
        do_read(9'd6, 9'd6, 2'b11);

        // R5 late write enable with data changing afterwards
        do_late_write(9'd8, 9'd3, 16'hc0de);
        do_read(9'd8, 9'd3, 2'b11);

        // R6 output enable rise and write enable fall end the EDO hold
        ras_n = 0; addr = 9'd8; step();
        addr = 9'd3; oe_n = 0; set_cas(2'b11); step();
        set_cas(2'b00); step();
        oe_n = 1; step();
        check("R6 off after oe high", drive_en, 2'b00);
        ras_n = 1; step();
        ras_n = 0; addr = 9'd8; step();
        addr = 9'd3; oe_n = 0; set_cas(2'b11); step();
        set_cas(2'b00); step();
        we_n = 0; step();
        check("R6 off after we low", drive_en, 2'b00);
        we_n = 1; ras_n = 1; oe_n = 1; step();
        do_read(9'd8, 9'd3, 2'b11);

        // R8 counter refresh leaves data untouched
        do_cbr();
        do_read(9'd3, 9'd5, 2'b11);

        // R10 hidden refresh
        do_hidden(9'd4, 9'd2, 2'b11);
        do_hidden(9'd3, 9'd5, 2'b01);

        // R7 directed page mode
        do_page_write(9'd10, 2'b11);
        do_page_read(9'd10, 2'b11);

        refresh_burst();

        // Random phase with periodic refresh bursts
        for (int i = 0; i < 200; i++) begin
            logic [8:0]  r, c;
            logic [1:0]  ln;
            r = 9'($urandom); c = 9'($urandom);
            ln = 2'($urandom_range(1, 3));
            if (cyc - last_burst > 300) refresh_burst();
            case ($urandom_range(0, 6))
                0: do_write(r, c, ln, 16'($urandom));
                1: do_read(r, c, ln);
                2: do_page_read(r, ln);
                3: do_page_write(r, ln);
                4: do_ras_only(r);
                5: do_hidden(r, c, ln);
                default: do_late_write(r, c, 16'($urandom));
            endcase
        end
        check("R11 no error while refreshed", refresh_err, 1'b0);

        // R8/R9/R11: counter refreshes plus one row-only, one row left out
        begin
            int t0, s, missing;
            refresh_burst();
            t0 = cyc;
            while (cyc < t0 + 400) step();
            s = cbr_model % 16;
            for (int k = 0; k < 14; k++) begin
                ras_n = 1; set_cas(2'b11); step();
                ras_n = 0; step();
                ras_n = 1; step();
                set_cas(2'b00); step();
                cbr_model++;
            end
            do_ras_only(9'((((s + 15) % 16)) | 9'h070));
            missing = (s + 14) % 16;
            while (cyc < t0 + 700) step();
            check("R11 no error before deadline", refresh_err, 1'b0);
            while (cyc < t0 + 900) step();
            check("R11 error raised", refresh_err, 1'b1);
            check("R8 R11 expired row from counter order", refresh_err_row, 9'(missing));
            repeat (20) step();
            check("R11 error sticky", refresh_err, 1'b1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule